// File: doc/BRIEF.md
# Sprite Zero Overlap Detector

This block watches the pixel stream of a tile-based video pipeline and raises a sticky status flag the first time, in a frame, that an opaque pixel of the sprite in slot 0 lands on an opaque background pixel. On every pixel clock it takes the beam position (screen column, scanline and line cycle), the 2-bit background pixel, the 2-bit winning sprite pixel, a marker telling whether that sprite came from slot 0, the sprite's own y coordinate and its priority bit. The upstream stages choose the sprite and mix the layers. This block only judges the overlap.

Some positions never produce a hit, even with two opaque pixels: the last screen column, a sprite whose y coordinate is 255, pixels outside the visible area, and any pixel while rendering is off. Once the flag is set it holds until the pre-render scanline, where it is cleared on a single line cycle. A processor-side read port captures a status byte with the flag in bit 6.

Top module: `szh_sprite0_hit`

## Requirements
- R1: A hit is registered only when the background pixel and the sprite pixel are both non-zero; a value of 0 on either means transparent.
- R2: Only a pixel whose winning sprite is flagged as slot 0 (`spr_slot0` = 1) can register a hit; opaque overlaps by any other sprite leave the flag unchanged.
- R3: No hit is registered at screen column 255, whatever the pixel values.
- R4: No hit is registered when the sprite's y coordinate (`spr_y`) equals 255.
- R5: On a pixel clock (`pix_en` = 1) with scanline 261 and line cycle 1, the flag is cleared on the next clock edge. Line cycle 0 of that scanline, and the same position with `pix_en` = 0, do not clear it.
- R6: Once set, the flag stays at 1 through any later pixels, hits or not, until the clear of R5.
- R7: Hits are evaluated only when `pix_en` = 1, `render_en` = 1, the column is below 256 and the scanline is below 240.
- R8: The sprite priority input (`spr_behind`) has no effect; a sprite drawn behind the background still registers a hit.
- R9: A clock with `rd_en` = 1 loads `rd_data` with the flag value held before that edge in bit 6, and all other bits 0. `rd_data` holds between reads, and a read never clears the flag.
- R10: Reset (`rst_n` = 0) clears the flag and `rd_data` to 0.
- R11: A new hit changes `hit_flag` one clock after the qualifying pixel is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; inputs describe one pixel when high |
| render_en | input | 1 | Rendering is enabled |
| scan_x | input | 8 | Screen column of the current pixel |
| scan_y | input | 9 | Current scanline, 0 to 261 |
| line_cyc | input | 9 | Line cycle within the scanline |
| bg_pix | input | 2 | Background pixel value, 0 = transparent |
| spr_pix | input | 2 | Winning sprite pixel value, 0 = transparent |
| spr_slot0 | input | 1 | Winning sprite came from slot 0 |
| spr_y | input | 8 | Y coordinate of the winning sprite |
| spr_behind | input | 1 | Sprite priority bit (ignored) |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | 8 | Captured status byte, flag in bit 6 |
| hit_flag | output | 1 | Current sticky hit flag |

## Verification
A status read can fall in the same cycle as a flag change: either a qualifying overlap that sets the flag, or the pre-render clear that drops it. The bench provokes both on purpose, with a read strobe on the very pixel that sets the flag and on the clearing line cycle. It expects the captured byte to show the value from before the edge while `hit_flag` shows the new one. A random phase then mixes reads, overlaps and clears, and compares every clock against a behavioural model.

// File: rtl/szh_pkg.sv
package szh_pkg;

    localparam int PIX_W = 2;

    // One pixel's worth of layer data handed to the qualifier
    typedef struct packed {
        logic [PIX_W-1:0] bg;
        logic [PIX_W-1:0] spr;
        logic             slot0;
        logic             behind;
    } pix_sample_t;

    // Sticky flag register contents
    typedef struct packed {
        logic hit;
    } flag_state_t;

endpackage

// File: rtl/szh_qualify.sv
module szh_qualify
    import szh_pkg::*;
#(
    parameter int SCREEN_W    = 256,
    parameter int SCREEN_H    = 240,
    parameter int X_W         = 8,
    parameter int Y_W         = 9,
    parameter int SY_W        = 8,
    parameter bit EXCL_EDGE   = 1'b1,
    parameter bit EXCL_SPR_Y  = 1'b1,
    parameter int BLANK_SPR_Y = 255
) (
    input  logic            pix_en,
    input  logic            render_en,
    input  logic [X_W-1:0]  scan_x,
    input  logic [Y_W-1:0]  scan_y,
    input  logic [SY_W-1:0] spr_y,
    input  pix_sample_t     smp,
    output logic            hit_o
);
    localparam int EDGE_X = SCREEN_W - 1;

    logic in_area;
    logic both_opaque;
    logic edge_ok;
    logic spry_ok;
    logic behind_unused;

    // priority is intentionally not part of the decision (R8)
    assign behind_unused = smp.behind;

    always_comb begin
        in_area = ({{(32-X_W){1'b0}}, scan_x} < 32'(SCREEN_W)) &&
                  ({{(32-Y_W){1'b0}}, scan_y} < 32'(SCREEN_H));
        both_opaque = (smp.bg != '0) && (smp.spr != '0);
    end

    generate
        if (EXCL_EDGE) begin : g_edge
            assign edge_ok = (scan_x != X_W'(EDGE_X));
        end else begin : g_no_edge
            assign edge_ok = 1'b1;
        end
        if (EXCL_SPR_Y) begin : g_spry
            assign spry_ok = (spr_y != SY_W'(BLANK_SPR_Y));
        end else begin : g_no_spry
            assign spry_ok = 1'b1;
        end
    endgenerate

    assign hit_o = pix_en && render_en && in_area && both_opaque &&
                   smp.slot0 && edge_ok && spry_ok;

endmodule

// File: rtl/szh_clear_gen.sv
module szh_clear_gen #(
    parameter int Y_W      = 9,
    parameter int C_W      = 9,
    parameter int PRE_LINE = 261,
    parameter int CLR_CYC  = 1
) (
    input  logic           pix_en,
    input  logic [Y_W-1:0] scan_y,
    input  logic [C_W-1:0] line_cyc,
    output logic           clr_o
);
    assign clr_o = pix_en &&
                   (scan_y == Y_W'(PRE_LINE)) &&
                   (line_cyc == C_W'(CLR_CYC));
endmodule

// File: rtl/szh_flag.sv
module szh_flag
    import szh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.hit = 1'b0;
        end else if (set_i) begin
            st_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.hit;

    // R6: sticky until the clear pulse
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/szh_status.sv
module szh_status #(
    parameter int STAT_W   = 8,
    parameter int FLAG_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              flag_i,
    output logic [STAT_W-1:0] rd_data
);
    typedef struct packed {
        logic [STAT_W-1:0] data;
    } rd_state_t;

    rd_state_t         rd_d, rd_q;
    logic [STAT_W-1:0] image;

    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_bit
            if (i == FLAG_BIT) begin : g_flag
                assign image[i] = flag_i;
            end else begin : g_zero
                assign image[i] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = image;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

    // R9: captured byte reflects the pre-edge flag in its bit
    a_r9_read_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data[FLAG_BIT] == $past(flag_i)));
    // R9: no other status bit is ever driven
    a_r9_only_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_data) && (rd_data[FLAG_BIT] || rd_data == '0));
    // R9: byte holds when no read
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/szh_sprite0_hit.sv
module szh_sprite0_hit
    import szh_pkg::*;
#(
    parameter int SCREEN_W    = 256,
    parameter int SCREEN_H    = 240,
    parameter int PRE_LINE    = 261,
    parameter int LINE_CYCLES = 341,
    parameter int CLR_CYC     = 1,
    parameter int BLANK_SPR_Y = 255,
    parameter int STAT_W      = 8,
    parameter int FLAG_BIT    = 6,
    parameter int X_W         = $clog2(SCREEN_W),
    parameter int Y_W         = $clog2(PRE_LINE + 1),
    parameter int C_W         = $clog2(LINE_CYCLES),
    parameter int SY_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              render_en,
    input  logic [X_W-1:0]    scan_x,
    input  logic [Y_W-1:0]    scan_y,
    input  logic [C_W-1:0]    line_cyc,
    input  logic [PIX_W-1:0]  bg_pix,
    input  logic [PIX_W-1:0]  spr_pix,
    input  logic              spr_slot0,
    input  logic [SY_W-1:0]   spr_y,
    input  logic              spr_behind,
    input  logic              rd_en,
    output logic [STAT_W-1:0] rd_data,
    output logic              hit_flag
);
    localparam int EDGE_X = SCREEN_W - 1;

    pix_sample_t smp;
    logic        hit_now;
    logic        clr_now;

    assign smp = '{bg: bg_pix, spr: spr_pix, slot0: spr_slot0, behind: spr_behind};

    szh_qualify #(
        .SCREEN_W   (SCREEN_W),
        .SCREEN_H   (SCREEN_H),
        .X_W        (X_W),
        .Y_W        (Y_W),
        .SY_W       (SY_W),
        .EXCL_EDGE  (1'b1),
        .EXCL_SPR_Y (1'b1),
        .BLANK_SPR_Y(BLANK_SPR_Y)
    ) u_qual (
        .pix_en   (pix_en),
        .render_en(render_en),
        .scan_x   (scan_x),
        .scan_y   (scan_y),
        .spr_y    (spr_y),
        .smp      (smp),
        .hit_o    (hit_now)
    );

    szh_clear_gen #(
        .Y_W     (Y_W),
        .C_W     (C_W),
        .PRE_LINE(PRE_LINE),
        .CLR_CYC (CLR_CYC)
    ) u_clr (
        .pix_en  (pix_en),
        .scan_y  (scan_y),
        .line_cyc(line_cyc),
        .clr_o   (clr_now)
    );

    szh_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (hit_now),
        .clr_i (clr_now),
        .flag_o(hit_flag)
    );

    szh_status #(
        .STAT_W  (STAT_W),
        .FLAG_BIT(FLAG_BIT)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .flag_i (hit_flag),
        .rd_data(rd_data)
    );

    // R1: a rising flag follows two opaque pixels
    a_r1_opaque: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(bg_pix) != '0 && $past(spr_pix) != '0));
    // R2: only slot 0 raises the flag
    a_r2_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> $past(spr_slot0));
    // R3: never from the last column
    a_r3_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(scan_x) != X_W'(EDGE_X)));
    // R4: never from a sprite at y 255
    a_r4_spr_y: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(spr_y) != SY_W'(BLANK_SPR_Y)));
    // R7: only while rendering inside the visible area
    a_r7_area: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_flag) |-> ($past(pix_en) && $past(render_en) &&
                             $past(scan_y) < Y_W'(SCREEN_H)));
    // R5: the pre-render position clears the flag
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && scan_y == Y_W'(PRE_LINE) && line_cyc == C_W'(CLR_CYC))
        |=> !hit_flag);

endmodule

// File: tb/tb_szh_sprite0_hit.sv
module tb_szh_sprite0_hit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0, render_en = 1'b0, spr_slot0 = 1'b0;
    logic       spr_behind = 1'b0, rd_en = 1'b0;
    logic [7:0] scan_x = '0;
    logic [8:0] scan_y = '0, line_cyc = '0;
    logic [1:0] bg_pix = '0, spr_pix = '0;
    logic [7:0] spr_y = '0;
    logic [7:0] rd_data;
    logic       hit_flag;

    int checks = 0, failures = 0;
    string ph = "R10 reset";
    bit m_flag;
    logic [7:0] m_rd;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    szh_sprite0_hit dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .render_en(render_en),
        .scan_x(scan_x), .scan_y(scan_y), .line_cyc(line_cyc),
        .bg_pix(bg_pix), .spr_pix(spr_pix), .spr_slot0(spr_slot0),
        .spr_y(spr_y), .spr_behind(spr_behind), .rd_en(rd_en),
        .rd_data(rd_data), .hit_flag(hit_flag)
    );

    // behavioural reference, from the requirements
    always @(posedge clk or negedge rst_n) begin
        bit hit, clr;
        if (!rst_n) begin
            m_flag = 0;
            m_rd   = 8'h00;
        end else begin
            hit = pix_en && render_en && (int'(scan_x) < 256) && (int'(scan_y) < 240) &&
                  bg_pix != 0 && spr_pix != 0 && spr_slot0 &&
                  int'(scan_x) != 255 && int'(spr_y) != 255;
            clr = pix_en && int'(scan_y) == 261 && int'(line_cyc) == 1;
            if (rd_en) m_rd = m_flag ? 8'h40 : 8'h00;
            if (clr) m_flag = 0;
            else if (hit) m_flag = 1;
        end
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (hit_flag !== m_flag || rd_data !== m_rd) begin
                failures++;
                $display("FAIL %s: flag=%0b rd=%02h expected flag=%0b rd=%02h",
                         ph, hit_flag, rd_data, m_flag, m_rd);
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic pix(input int x, input int y, input int c, input int bg,
                       input int sp, input bit s0, input int sy, input bit beh,
                       input bit rd);
        pix_en = 1'b1; render_en = 1'b1;
        scan_x = 8'(x); scan_y = 9'(y); line_cyc = 9'(c);
        bg_pix = 2'(bg); spr_pix = 2'(sp); spr_slot0 = s0;
        spr_y = 8'(sy); spr_behind = beh; rd_en = rd;
        tick();
        rd_en = 1'b0; bg_pix = 2'd0; spr_pix = 2'd0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R10 reset flag", {7'd0, hit_flag}, 8'h00);
        chk("R10 reset rd", rd_data, 8'h00);
        rst_n = 1'b1;
        tick();

        ph = "R1";
        pix(10, 20, 30, 0, 3, 1, 50, 0, 0);
        chk("R1 bg transparent", {7'd0, hit_flag}, 8'h00);
        pix(10, 20, 30, 2, 0, 1, 50, 0, 0);
        chk("R1 sprite transparent", {7'd0, hit_flag}, 8'h00);
        ph = "R2";
        pix(11, 20, 31, 1, 1, 0, 50, 0, 0);
        chk("R2 other slot", {7'd0, hit_flag}, 8'h00);
        ph = "R3";
        pix(255, 20, 256, 3, 3, 1, 50, 0, 0);
        chk("R3 column 255", {7'd0, hit_flag}, 8'h00);
        ph = "R4";
        pix(40, 20, 41, 3, 3, 1, 255, 0, 0);
        chk("R4 sprite y 255", {7'd0, hit_flag}, 8'h00);
        ph = "R7";
        pix(40, 240, 41, 3, 3, 1, 50, 0, 0);
        chk("R7 scanline 240", {7'd0, hit_flag}, 8'h00);
        render_en = 1'b0; pix_en = 1'b1; scan_y = 9'd20; scan_x = 8'd40;
        bg_pix = 2'd3; spr_pix = 2'd3; spr_slot0 = 1'b1; spr_y = 8'd50;
        tick();
        chk("R7 render off", {7'd0, hit_flag}, 8'h00);
        render_en = 1'b1; pix_en = 1'b0;
        tick();
        chk("R7 no pixel clock", {7'd0, hit_flag}, 8'h00);
        bg_pix = 2'd0; spr_pix = 2'd0;

        ph = "R9";
        pix(0, 0, 1, 0, 0, 0, 0, 0, 1);
        chk("R9 read while clear", rd_data, 8'h00);

        ph = "R8";
        pix(254, 239, 255, 2, 1, 1, 254, 1, 1);   // read in the setting cycle
        chk("R8 behind sprite hits", {7'd0, hit_flag}, 8'h01);
        chk("R11 flag one clock later", {7'd0, hit_flag}, 8'h01);
        chk("R9 read same cycle as set shows old", rd_data, 8'h00);
        pix(5, 5, 6, 0, 0, 0, 0, 0, 1);
        chk("R9 read shows flag", rd_data, 8'h40);
        chk("R9 read does not clear", {7'd0, hit_flag}, 8'h01);

        ph = "R6";
        pix(6, 6, 7, 3, 3, 1, 9, 0, 0);
        pix(7, 6, 8, 0, 0, 0, 9, 0, 0);
        chk("R6 sticky", {7'd0, hit_flag}, 8'h01);

        ph = "R5";
        pix(0, 261, 0, 0, 0, 0, 0, 0, 0);
        chk("R5 cycle 0 keeps flag", {7'd0, hit_flag}, 8'h01);
        pix_en = 1'b0; scan_y = 9'd261; line_cyc = 9'd1;
        tick();
        chk("R5 no pixel clock keeps flag", {7'd0, hit_flag}, 8'h01);
        pix(0, 261, 1, 0, 0, 0, 0, 0, 1);
        chk("R5 cleared", {7'd0, hit_flag}, 8'h00);
        chk("R9 read on clear shows old", rd_data, 8'h40);
        pix(0, 261, 2, 0, 0, 0, 0, 0, 1);
        chk("R9 read after clear", rd_data, 8'h00);
        pix(100, 100, 101, 1, 2, 1, 3, 0, 0);
        chk("R11 new frame hit", {7'd0, hit_flag}, 8'h01);

        ph = "random R1 R2 R3 R4 R5 R6 R7 R8 R9";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 7));
            pix_en    = ($urandom_range(0, 9) != 0);
            render_en = ($urandom_range(0, 9) != 0);
            scan_x    = (r == 0) ? 8'd255 : 8'($urandom_range(0, 255));
            scan_y    = (r == 1) ? 9'd261 : (r == 2) ? 9'd239 : 9'($urandom_range(0, 261));
            line_cyc  = 9'($urandom_range(0, 2));
            bg_pix    = 2'($urandom_range(0, 3));
            spr_pix   = 2'($urandom_range(0, 3));
            spr_slot0 = ($urandom_range(0, 2) != 0);
            spr_y     = (r == 3) ? 8'd255 : 8'($urandom_range(0, 255));
            spr_behind = 1'($urandom_range(0, 1));
            rd_en     = ($urandom_range(0, 3) == 0);
            tick();
        end
        rd_en = 1'b0;
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule